// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block drives the word-address side of a synchronous burst read from a 16-bit-wide memory array. A one-cycle latch strobe captures a start word address and a configuration word. After an initial wait of X clock cycles, the block places a new array address on its output and raises a data-valid strobe. It then issues one word every Y cycles until the burst is done. A burst is 4 words, 8 words or unbounded. Fixed-length bursts wrap inside their aligned group in either sequential or interleaved order. Unbounded bursts count upward linearly.

A ready flag with its own output-enable follows the validity of the data, but only for unbounded bursts. The flag can either match the data-valid cycle or lead it by one cycle. A configuration bit moves all outputs from the rising to the falling clock edge. The memory array and the asynchronous and page read paths lie outside this block.

The outbound stream is `arr_addr` qualified by `data_vld`. It has no ready input and no back-pressure: the consumer must take every beat in the cycle it is shown. `arr_addr` carries no meaning while `data_vld` is low.

Top module: `burst_seq_top`

## Requirements
- R1: While reset is asserted, and after reset until the first strobe, `data_vld`, `rdy_o` and `rdy_oe` are 0 and `arr_addr` is 0.
- R2: The configuration word is laid out as follows: bits [2:0] are the length code, bit 3 is the order, bits [7:4] are the raw X value, bit 8 is the Y select, bit 9 is the edge select and bit 10 is the ready lead. Length code 001 gives 4 words, 010 gives 8 words and 111 is unbounded. Any other code starts no burst: `data_vld` stays 0 until the next strobe, and any burst in progress stops.
- R3: When bit 3 is 0 and the length is 4 or 8 words, beat j reads word ((s + j) mod N) of the aligned N-word group that holds start word s. For example, a 4-word burst from word 2 reads 2,3,0,1.
- R4: When bit 3 is 1 and the length is 4 or 8 words, beat j reads the low index (s mod N) XOR j inside the same aligned group. For example, an 8-word burst from word 5 reads 5,4,7,6,1,0,3,2.
- R5: For an unbounded burst, beat j reads address s + j with no wrap, and bit 3 has no effect.
- R6: Count the clock edge that captures the strobe as edge 0. The first beat is valid after edge X. A raw X of 2 to 8 is used as given, and any other raw value acts as 8.
- R7: Beat j is valid after edge X + j·Y, where Y is 1 when bit 8 is 0 and 2 when bit 8 is 1. When Y is 2, valid and not-valid cycles alternate.
- R8: `rdy_oe` is 1 from the strobe edge onward only when the captured length code is 111. Otherwise `rdy_oe` is 0, and `rdy_o` is 0 whenever `rdy_oe` is 0.
- R9: With bit 10 at 0, `rdy_o` equals `data_vld` in the same cycle. With bit 10 at 1, `rdy_o` equals the `data_vld` of the following cycle.
- R10: With bit 9 at 0, all outputs change on rising edges. With bit 9 at 1, they change half a cycle later, on the falling edge that follows.
- R11: A strobe aborts any burst in progress. `data_vld` is 0 in the cycle after the strobe edge, and the new burst's timing counts from that edge.
- R12: The configuration and start address are used only at the strobe edge. Changing them between strobes has no effect on the burst in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat_stb | input | 1 | Latch strobe; captures start address and configuration |
| start_addr | input | AW | Start word address |
| cfg_word | input | 11 | Burst configuration word (layout in R2) |
| arr_addr | output | AW | Array word address of the current beat |
| data_vld | output | 1 | Beat valid strobe, no back-pressure |
| rdy_oe | output | 1 | Drive enable of the ready flag (0 models high impedance) |
| rdy_o | output | 1 | Ready flag, low when data is not valid |

## Verification
A wrong beat counter or base register shows up as a wrong `arr_addr` on the next valid beat. A wrong latency or Y counter moves `data_vld` by at least one cycle, either at the first beat or at the next one. A wrong length latch makes a burst end early or run past its last beat within one beat time. Because every cycle of each burst is compared against an independent model, any of these faults is reported within one beat of its first visible effect. The edge select can only be seen within a cycle, so it is probed on both sides of the falling edge.

// File: rtl/burst_seq_pkg.sv
`timescale 1ns/1ps
package burst_seq_pkg;
  localparam int CFG_W    = 11;
  localparam int LEN_LSB  = 0;
  localparam int ORD_BIT  = 3;
  localparam int XLAT_LSB = 4;
  localparam int XLAT_W   = 4;
  localparam int YSEL_BIT = 8;
  localparam int EDGE_BIT = 9;
  localparam int LEAD_BIT = 10;

  localparam logic [2:0] LEN_FOUR  = 3'b001;
  localparam logic [2:0] LEN_EIGHT = 3'b010;
  localparam logic [2:0] LEN_UNBND = 3'b111;

  localparam logic [XLAT_W-1:0] XLAT_MIN = 4'd2;
  localparam logic [XLAT_W-1:0] XLAT_MAX = 4'd8;

  typedef struct packed {
    logic              ok;
    logic              cont;
    logic [2:0]        nm1;
    logic              ilv;
    logic [XLAT_W-1:0] xlat;
    logic              y2;
    logic              fall;
    logic              lead;
  } bseq_cfg_t;
endpackage

// File: rtl/bseq_cfg_decode.sv
`timescale 1ns/1ps
module bseq_cfg_decode
  import burst_seq_pkg::*;
(
  input  logic [CFG_W-1:0] raw,
  output bseq_cfg_t        cfg
);
  logic [2:0]        len;
  logic [XLAT_W-1:0] xraw;

  assign len  = raw[LEN_LSB +: 3];
  assign xraw = raw[XLAT_LSB +: XLAT_W];

  always_comb begin
    cfg      = '0;
    cfg.ilv  = raw[ORD_BIT];
    cfg.y2   = raw[YSEL_BIT];
    cfg.fall = raw[EDGE_BIT];
    cfg.lead = raw[LEAD_BIT];
    cfg.xlat = (xraw >= XLAT_MIN && xraw <= XLAT_MAX) ? xraw : XLAT_MAX;
    unique case (len)
      LEN_FOUR:  begin cfg.ok = 1'b1; cfg.nm1 = 3'd3; end
      LEN_EIGHT: begin cfg.ok = 1'b1; cfg.nm1 = 3'd7; end
      LEN_UNBND: begin cfg.ok = 1'b1; cfg.cont = 1'b1; cfg.nm1 = 3'd7; end
      default:   begin cfg.ok = 1'b0; cfg.nm1 = 3'd3; end
    endcase
  end
endmodule

// File: rtl/bseq_addr_map.sv
`timescale 1ns/1ps
module bseq_addr_map #(
  parameter int AW = 21
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] beat,
  input  logic          cont,
  input  logic          ilv,
  input  logic [2:0]    nm1,
  output logic [AW-1:0] addr
);
  localparam int GRP_BITS = 3;

  logic [AW-1:0] lin;
  logic [AW-1:0] xr;
  logic [AW-1:0] wrapped;
  logic [GRP_BITS-1:0] mask;

  assign lin  = base + beat;
  assign xr   = base ^ beat;
  assign mask = nm1;

  // Bits inside the wrap group come from the selected order, bits above are held.
  genvar gi;
  generate
    for (gi = 0; gi < AW; gi++) begin : g_bit
      if (gi < GRP_BITS) begin : g_low
        assign wrapped[gi] = mask[gi] ? (ilv ? xr[gi] : lin[gi]) : base[gi];
      end else begin : g_high
        assign wrapped[gi] = base[gi];
      end
    end
  endgenerate

  assign addr = cont ? lin : wrapped;
endmodule

// File: rtl/bseq_engine.sv
`timescale 1ns/1ps
module bseq_engine
  import burst_seq_pkg::*;
#(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic [AW-1:0] start,
  input  bseq_cfg_t     cfg_in,
  output logic          vld_a,
  output logic [AW-1:0] addr_a,
  output logic          q_cont,
  output logic          q_y2,
  output logic          q_lead,
  output logic          q_fall
);
  logic              active;
  logic [XLAT_W-1:0] cnt;
  logic [AW-1:0]     beat;
  logic [AW-1:0]     base;
  logic              q_ilv;
  logic [2:0]        q_nm1;
  logic [AW-1:0]     next_addr;
  logic              last_beat;

  bseq_addr_map #(.AW(AW)) u_map (
    .base (base),
    .beat (beat),
    .cont (q_cont),
    .ilv  (q_ilv),
    .nm1  (q_nm1),
    .addr (next_addr)
  );

  assign last_beat = !q_cont && (beat[2:0] == q_nm1);

  // Runs one cycle ahead of the outputs, so the wait is loaded with X-2.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      beat   <= '0;
      base   <= '0;
      vld_a  <= 1'b0;
      addr_a <= '0;
      q_cont <= 1'b0;
      q_ilv  <= 1'b0;
      q_nm1  <= 3'd3;
      q_y2   <= 1'b0;
      q_lead <= 1'b0;
      q_fall <= 1'b0;
    end else if (stb) begin
      active <= cfg_in.ok;
      cnt    <= cfg_in.xlat - XLAT_MIN;
      beat   <= '0;
      base   <= start;
      vld_a  <= 1'b0;
      q_cont <= cfg_in.cont;
      q_ilv  <= cfg_in.ilv;
      q_nm1  <= cfg_in.nm1;
      q_y2   <= cfg_in.y2;
      q_lead <= cfg_in.lead;
      q_fall <= cfg_in.fall;
    end else if (active) begin
      if (cnt != '0) begin
        cnt   <= cnt - 1'b1;
        vld_a <= 1'b0;
      end else begin
        vld_a  <= 1'b1;
        addr_a <= next_addr;
        beat   <= beat + 1'b1;
        cnt    <= q_y2 ? XLAT_W'(1) : '0;
        if (last_beat) active <= 1'b0;
      end
    end else begin
      vld_a <= 1'b0;
    end
  end
endmodule

// File: rtl/bseq_out_stage.sv
`timescale 1ns/1ps
module bseq_out_stage #(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          vld_a,
  input  logic [AW-1:0] addr_a,
  input  logic          q_cont,
  input  logic          q_lead,
  input  logic          q_fall,
  output logic [AW-1:0] arr_addr,
  output logic          data_vld,
  output logic          rdy_oe,
  output logic          rdy_o
);
  logic          vld_b, vld_n;
  logic [AW-1:0] addr_b, addr_n;
  logic          rdy_r, rdy_n, oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_b  <= 1'b0;
      addr_b <= '0;
    end else begin
      vld_b <= stb ? 1'b0 : vld_a;
      if (vld_a && !stb) addr_b <= addr_a;
    end
  end

  assign rdy_r = q_cont & (q_lead ? vld_a : vld_b);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_n  <= 1'b0;
      addr_n <= '0;
      rdy_n  <= 1'b0;
      oe_n   <= 1'b0;
    end else begin
      vld_n  <= vld_b;
      addr_n <= addr_b;
      rdy_n  <= rdy_r;
      oe_n   <= q_cont;
    end
  end

  assign data_vld = q_fall ? vld_n  : vld_b;
  assign arr_addr = q_fall ? addr_n : addr_b;
  assign rdy_o    = q_fall ? rdy_n  : rdy_r;
  assign rdy_oe   = q_fall ? oe_n   : q_cont;
endmodule

// File: rtl/burst_seq_top.sv
`timescale 1ns/1ps
module burst_seq_top
  import burst_seq_pkg::*;
#(
  parameter int AW = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lat_stb,
  input  logic [AW-1:0]    start_addr,
  input  logic [CFG_W-1:0] cfg_word,
  output logic [AW-1:0]    arr_addr,
  output logic             data_vld,
  output logic             rdy_oe,
  output logic             rdy_o
);
  bseq_cfg_t     cfg_dec;
  logic          vld_a;
  logic [AW-1:0] addr_a;
  logic          q_cont, q_y2, q_lead, q_fall;

  bseq_cfg_decode u_dec (
    .raw (cfg_word),
    .cfg (cfg_dec)
  );

  bseq_engine #(.AW(AW)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (lat_stb),
    .start  (start_addr),
    .cfg_in (cfg_dec),
    .vld_a  (vld_a),
    .addr_a (addr_a),
    .q_cont (q_cont),
    .q_y2   (q_y2),
    .q_lead (q_lead),
    .q_fall (q_fall)
  );

  bseq_out_stage #(.AW(AW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (lat_stb),
    .vld_a    (vld_a),
    .addr_a   (addr_a),
    .q_cont   (q_cont),
    .q_lead   (q_lead),
    .q_fall   (q_fall),
    .arr_addr (arr_addr),
    .data_vld (data_vld),
    .rdy_oe   (rdy_oe),
    .rdy_o    (rdy_o)
  );
endmodule

// File: rtl/burst_seq_chk.sv
`timescale 1ns/1ps
module burst_seq_chk #(
  parameter int AW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lat_stb,
  input logic          data_vld,
  input logic          rdy_oe,
  input logic          rdy_o,
  input logic          vld_a,
  input logic [AW-1:0] addr_a,
  input logic          q_cont,
  input logic          q_y2,
  input logic          q_lead,
  input logic          q_fall
);
  // R11
  abort_clears_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_stb |=> !data_vld);

  // R7
  y2_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_y2 && vld_a && !lat_stb) |=> !vld_a);

  // R9
  rdy_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_oe && q_lead && !q_fall && !lat_stb) |=> (data_vld == $past(rdy_o)));

  // R5
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_a && q_cont && !lat_stb) |=> (!vld_a || addr_a == AW'($past(addr_a) + 1'b1)));

  // R3
  wrap_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_a && !q_cont && !lat_stb) |=> (!vld_a || (addr_a >> 3) == ($past(addr_a) >> 3)));
endmodule

bind burst_seq_top burst_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/burst_seq_top_test.sv
`timescale 1ns/1ps
module burst_seq_top_test;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lat_stb = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [10:0]   cfg_word = '0;
  logic [AW-1:0] arr_addr;
  logic          data_vld, rdy_oe, rdy_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_seq_top #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .lat_stb(lat_stb), .start_addr(start_addr),
    .cfg_word(cfg_word), .arr_addr(arr_addr), .data_vld(data_vld),
    .rdy_oe(rdy_oe), .rdy_o(rdy_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [10:0] mk_cfg(input logic [2:0] len, input bit ilv, input logic [3:0] xr,
                                         input bit y2, input bit fall, input bit lead);
    return {lead, fall, y2, xr, ilv, len};
  endfunction

  function automatic int eff_x(input logic [3:0] xr);
    return (xr >= 2 && xr <= 8) ? int'(xr) : 8;
  endfunction

  function automatic int n_words(input logic [2:0] len);
    case (len)
      3'b001: return 4;
      3'b010: return 8;
      3'b111: return -1;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_vld(input int t, input int x, input int y, input int n);
    if (n == 0 || t < x) return 0;
    if ((t - x) % y != 0) return 0;
    if (n > 0 && (t - x) / y >= n) return 0;
    return 1;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] s, input int n, input bit ilv, input int j);
    int lo;
    if (n < 0) return s + AW'(j);
    lo = int'(s) % n;
    lo = ilv ? (lo ^ j) : ((lo + j) % n);
    return s - AW'(int'(s) % n) + AW'(lo);
  endfunction

  // One burst: strobe, scramble inputs (R12), then compare ncyc cycles.
  task automatic run(input logic [2:0] len, input bit ilv, input logic [3:0] xr, input bit y2,
                     input bit fall, input bit lead, input logic [AW-1:0] s, input int ncyc);
    int x, y, n;
    bit ev, evn;
    x = eff_x(xr); y = y2 ? 2 : 1; n = n_words(len);
    @(posedge clk); #1;
    lat_stb = 1'b1; start_addr = s; cfg_word = mk_cfg(len, ilv, xr, y2, fall, lead);
    @(posedge clk); #1;
    lat_stb = 1'b0; cfg_word = 11'($urandom); start_addr = AW'($urandom);
    #2.5;
    for (int t = 0; t < ncyc; t++) begin
      ev  = exp_vld(t, x, y, n);
      evn = exp_vld(t + 1, x, y, n);
      chk(data_vld == ev, "R6/R7/R11 data_vld", data_vld, ev);
      if (ev && data_vld)
        chk(arr_addr == exp_addr(s, n, ilv, (t - x) / y),
            n < 0 ? "R5 addr" : (ilv ? "R4 addr" : "R3 addr"),
            arr_addr, exp_addr(s, n, ilv, (t - x) / y));
      chk(rdy_oe == (n < 0), "R8 rdy_oe", rdy_oe, (n < 0));
      chk(rdy_o == ((n < 0) && (lead ? evn : ev)), "R9 rdy_o", rdy_o, ((n < 0) && (lead ? evn : ev)));
      @(posedge clk); #3.5;
    end
  endtask

  // R10: probe both sides of the falling edge at the first beat.
  task automatic edge_probe(input bit fall);
    @(posedge clk); #1;
    lat_stb = 1'b1; start_addr = 21'h40; cfg_word = mk_cfg(3'b001, 1'b0, 4'd3, 1'b0, fall, 1'b0);
    @(posedge clk); #1;
    lat_stb = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(data_vld == !fall, "R10 before falling edge", data_vld, !fall);
    #2.5;
    chk(data_vld == 1'b1, "R10 after falling edge", data_vld, 1);
    chk(arr_addr == 21'h40, "R10 addr", arr_addr, 21'h40);
    repeat (8) @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk(!data_vld && !rdy_oe && !rdy_o && arr_addr == '0, "R1 in reset", {data_vld, rdy_oe, rdy_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #3.5;
    chk(!data_vld && !rdy_oe && !rdy_o && arr_addr == '0, "R1 after reset", {data_vld, rdy_oe, rdy_o}, 0);

    run(3'b001, 0, 4'd2, 0, 0, 0, 21'h000102, 8);   // R3 2,3,0,1
    run(3'b010, 1, 4'd4, 0, 0, 0, 21'h000015, 14);  // R4 5,4,7,6,1,0,3,2
    run(3'b010, 0, 4'd8, 1, 0, 0, 21'h00003e, 26);  // R3 R7 wrap with gaps
    run(3'b111, 1, 4'd3, 0, 0, 0, 21'h1ffffd, 12);  // R5 wraps the address space, R9 same cycle
    run(3'b111, 0, 4'd2, 1, 0, 1, 21'h000100, 14);  // R7 R9 lead
    run(3'b111, 0, 4'd5, 1, 1, 1, 21'h000200, 14);  // R10 falling with lead
    run(3'b001, 0, 4'd0, 0, 0, 0, 21'h000007, 14);  // R6 clamp low
    run(3'b001, 1, 4'd15, 0, 0, 0, 21'h000009, 14); // R6 clamp high
    run(3'b000, 0, 4'd2, 0, 0, 0, 21'h000010, 10);  // R2 reserved
    run(3'b011, 0, 4'd2, 0, 0, 0, 21'h000010, 10);  // R2 reserved
    run(3'b010, 0, 4'd6, 1, 0, 0, 21'h000030, 9);   // R11 cut short by next strobe
    run(3'b001, 1, 4'd2, 0, 0, 0, 21'h000033, 8);   // R11 restart
    run(3'b111, 0, 4'd2, 0, 0, 1, 21'h000400, 5);   // R11 abort unbounded
    run(3'b100, 0, 4'd2, 0, 0, 0, 21'h000400, 8);   // R2 reserved stops a burst
    edge_probe(1'b0);
    edge_probe(1'b1);

    for (int i = 0; i < 40; i++) begin
      logic [2:0] len;
      logic [3:0] xr;
      bit ilv, y2, fall, lead;
      int n, span;
      len = 3'($urandom); xr = 4'($urandom);
      ilv = 1'($urandom); y2 = 1'($urandom); fall = 1'($urandom); lead = 1'($urandom);
      n = n_words(len);
      span = (n > 0) ? n : 8;
      run(len, ilv, xr, y2, fall, lead, AW'($urandom), eff_x(xr) + span * (y2 ? 2 : 1) + 2);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule